// File: doc/BRIEF.md
# Soft Mute Gain Ramp

This block sits in a digital audio playback path and fades a stream of signed 16-bit samples in and out. It lets the stream be muted without stopping it. Samples arrive one per sample-rate strobe. Each sample is multiplied by a gain that is held as a step count between zero and a full-scale value of 245. The scaled result leaves the block one clock later with a valid flag.

A single mute control bit picks the direction of the ramp. While the bit is set, the gain count falls by one step on every strobe until it reaches zero, where the output is silent. While the bit is clear, the count climbs by one step per strobe back to 245, where the output is an exact copy of the input. The bit can flip partway through a ramp. The count then turns around from wherever it stands, so a source switch never produces a jump in level.

The gain count is visible as an output. A status flag reports when the path is fully silent because of a mute request.

Top module: `soft_mute_ramp`

## Requirements
- R1: While reset is asserted and after it is released, before any strobe: the gain output reads 245, the sample output reads 0, the valid flag is 0 and the silent flag is 0.
- R2: The valid flag is high for exactly the clock that follows each strobe clock and low otherwise, whatever the gain or mute state.
- R3: On a strobe with the mute bit at 1, the gain count decreases by one if it is above 0. At 0 it stays at 0.
- R4: On a strobe with the mute bit at 0, the gain count increases by one if it is below 245. At 245 it stays at 245.
- R5: When the mute bit changes between strobes during a ramp, the next strobe moves the count by one step in the new direction, starting from its present value, with no jump.
- R6: The sample output for a strobe equals input × g / 245 truncated toward zero, where g is the gain count before that strobe's step. The result always lies in the signed 16-bit range.
- R7: At g = 245 the output equals the input exactly, including −32768 and 32767. At g = 0 the output is exactly 0.
- R8: The silent flag is 1 only while the gain count is 0 and the mute bit taken at the most recent strobe was 1.
- R9: The mute bit and the sample input are ignored on clocks without a strobe. The gain count and the outputs do not change on such clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| strobe_i | input | 1 | One-clock pulse marking a new input sample |
| sample_i | input | 16 | Signed input sample |
| mute_i | input | 1 | Mute request, 1 = fade to silence |
| sample_o | output | 16 | Signed scaled sample |
| valid_o | output | 1 | High for one clock when sample_o is new |
| gain_o | output | 8 | Current gain step count, 0 to 245 |
| muted_o | output | 1 | Path silent due to mute |

## Verification
On every strobe, a change of ramp direction and the scaling of that strobe's sample happen in the same clock. The sample must be scaled by the count as it stood before the turn, and the count must then move in the new direction. The bench provokes this by reversing the mute bit in mid-ramp, and also exactly at the ends: releasing on the strobe that sees the count at 1, and releasing on the strobe that sees it at 0. It judges each case by comparing every output sample and the gain count seen before every strobe against its own step model. Between strobes the bench drives the inverse of the mute bit and a changed sample, so a design that samples its inputs off-strobe diverges from the model.

// File: rtl/smr_pkg.sv
package smr_pkg;

    // Bits needed to hold a count from 0 to steps inclusive.
    function automatic int gain_bits(input int steps);
        return $clog2(steps + 1);
    endfunction

    // Rounded-up reciprocal of steps, scaled by 2^shift.
    function automatic logic [63:0] recip(input int steps, input int shift);
        logic [63:0] one;
        one = 64'd1 << shift;
        return (one + 64'(steps) - 64'd1) / 64'(steps);
    endfunction

endpackage

// File: rtl/smr_gain_ctrl.sv
module smr_gain_ctrl #(
    parameter int RAMP_STEPS = 245,
    parameter int GAIN_W     = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              strobe_i,
    input  logic              mute_i,
    output logic [GAIN_W-1:0] gain_o,
    output logic              mute_o
);

    localparam logic [GAIN_W-1:0] FULL = GAIN_W'(RAMP_STEPS);

    typedef struct packed {
        logic [GAIN_W-1:0] gain;
        logic              mute;
    } ramp_state_t;

    ramp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (strobe_i) begin
            st_d.mute = mute_i;
            if (mute_i) begin
                if (st_q.gain != '0) begin
                    st_d.gain = st_q.gain - 1'b1;
                end
            end else begin
                if (st_q.gain != FULL) begin
                    st_d.gain = st_q.gain + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.gain <= FULL;
            st_q.mute <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gain_o = st_q.gain;
    assign mute_o = st_q.mute;

endmodule

// File: rtl/smr_scaler.sv
module smr_scaler #(
    parameter int DATA_W     = 16,
    parameter int GAIN_W     = 8,
    parameter int RAMP_STEPS = 245
) (
    input  logic [DATA_W-1:0] sample_i,
    input  logic [GAIN_W-1:0] gain_i,
    output logic [DATA_W-1:0] scaled_o
);

    // Magnitude product width, and a shift wide enough for exact division.
    localparam int MAG_W  = DATA_W + GAIN_W;
    localparam int SHIFT  = DATA_W + 2 * GAIN_W;
    localparam int PROD_W = MAG_W + SHIFT + 1;
    localparam logic [63:0] RECIP = smr_pkg::recip(RAMP_STEPS, SHIFT);
    localparam logic [SHIFT:0] RECIP_V = RECIP[SHIFT:0];
    localparam logic [MAG_W-1:0] POS_LIM = MAG_W'((64'd1 << (DATA_W - 1)) - 64'd1);
    localparam logic [MAG_W-1:0] NEG_LIM = POS_LIM + 1'b1;

    logic              neg;
    logic [DATA_W-1:0] mag;
    logic [MAG_W-1:0]  prod;
    logic [PROD_W-1:0] wide;
    logic [MAG_W-1:0]  quo;
    logic [MAG_W-1:0]  clip;

    always_comb begin
        neg  = sample_i[DATA_W-1];
        mag  = neg ? (~sample_i + 1'b1) : sample_i;
        prod = MAG_W'(mag) * MAG_W'(gain_i);
        wide = PROD_W'(prod) * PROD_W'(RECIP_V);
        quo  = MAG_W'(wide >> SHIFT);
        if (neg) begin
            clip     = (quo > NEG_LIM) ? NEG_LIM : quo;
            scaled_o = DATA_W'(MAG_W'(0) - clip);
        end else begin
            clip     = (quo > POS_LIM) ? POS_LIM : quo;
            scaled_o = DATA_W'(clip);
        end
    end

endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp #(
    parameter int DATA_W     = 16,
    parameter int RAMP_STEPS = 245,
    parameter int GAIN_W     = smr_pkg::gain_bits(RAMP_STEPS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              strobe_i,
    input  logic [DATA_W-1:0] sample_i,
    input  logic              mute_i,
    output logic [DATA_W-1:0] sample_o,
    output logic              valid_o,
    output logic [GAIN_W-1:0] gain_o,
    output logic              muted_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } out_reg_t;

    logic [GAIN_W-1:0] gain_cur;
    logic              mute_seen;
    logic [DATA_W-1:0] scaled;
    out_reg_t          out_d, out_q;

    smr_gain_ctrl #(
        .RAMP_STEPS(RAMP_STEPS),
        .GAIN_W    (GAIN_W)
    ) u_gain (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .strobe_i(strobe_i),
        .mute_i  (mute_i),
        .gain_o  (gain_cur),
        .mute_o  (mute_seen)
    );

    smr_scaler #(
        .DATA_W    (DATA_W),
        .GAIN_W    (GAIN_W),
        .RAMP_STEPS(RAMP_STEPS)
    ) u_scale (
        .sample_i(sample_i),
        .gain_i  (gain_cur),
        .scaled_o(scaled)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = strobe_i;
        if (strobe_i) begin
            out_d.data = scaled;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign sample_o = out_q.data;
    assign valid_o  = out_q.valid;
    assign gain_o   = gain_cur;
    assign muted_o  = (gain_cur == '0) && mute_seen;

endmodule

// File: rtl/smr_checker.sv
module smr_checker #(
    parameter int DATA_W     = 16,
    parameter int RAMP_STEPS = 245,
    parameter int GAIN_W     = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              strobe_i,
    input logic              mute_i,
    input logic [DATA_W-1:0] sample_o,
    input logic              valid_o,
    input logic [GAIN_W-1:0] gain_o,
    input logic              muted_o
);

    localparam logic [GAIN_W-1:0] FULL = GAIN_W'(RAMP_STEPS);

    p_valid_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strobe_i |=> valid_o);

    p_valid_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !strobe_i |=> !valid_o);

    p_step_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe_i && mute_i && gain_o != '0) |=> (gain_o == $past(gain_o) - 1'b1));

    p_step_up_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe_i && !mute_i && gain_o != FULL) |=> (gain_o == $past(gain_o) + 1'b1));

    p_gain_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gain_o <= FULL);

    p_zero_out_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe_i && gain_o == '0) |=> (sample_o == '0));

    p_silent_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        muted_o |-> (gain_o == '0));

    p_hold_gain_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !strobe_i |=> $stable(gain_o));

    p_hold_out_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !strobe_i |=> $stable(sample_o));

endmodule

bind soft_mute_ramp smr_checker #(
    .DATA_W    (DATA_W),
    .RAMP_STEPS(RAMP_STEPS),
    .GAIN_W    (GAIN_W)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(strobe_i),
    .mute_i  (mute_i),
    .sample_o(sample_o),
    .valid_o (valid_o),
    .gain_o  (gain_o),
    .muted_o (muted_o)
);

// File: tb/sim_soft_mute_ramp.sv
`timescale 1ns/1ps
module sim_soft_mute_ramp;

    localparam int STEPS = 245;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe_i = 1'b0;
    logic [15:0] sample_i = '0;
    logic        mute_i = 1'b0;
    logic [15:0] sample_o;
    logic        valid_o;
    logic [7:0]  gain_o;
    logic        muted_o;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int    exp_q[$];
    string tag_q[$];
    int    mdl_gain = STEPS;
    bit    mdl_mute = 1'b0;
    logic  last_strobe = 1'b0;

    always #10 clk = ~clk;

    soft_mute_ramp u0 (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .strobe_i(strobe_i),
        .sample_i(sample_i),
        .mute_i  (mute_i),
        .sample_o(sample_o),
        .valid_o (valid_o),
        .gain_o  (gain_o),
        .muted_o (muted_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One strobe, then one idle clock with inverted mute and altered data (R9).
    task automatic drive(input int s, input bit m, input string tag);
        int e;
        @(negedge clk);
        check(int'(gain_o) == mdl_gain, tag, int'(gain_o), mdl_gain);
        check(muted_o == (mdl_gain == 0 && mdl_mute), "R8", int'(muted_o),
              int'(mdl_gain == 0 && mdl_mute));
        strobe_i = 1'b1;
        sample_i = 16'(s);
        mute_i   = m;
        e = (s * mdl_gain) / STEPS;
        exp_q.push_back(e);
        tag_q.push_back((mdl_gain == 0 || mdl_gain == STEPS) ? "R7" : "R6");
        mdl_mute = m;
        if (m && mdl_gain > 0) mdl_gain--;
        else if (!m && mdl_gain < STEPS) mdl_gain++;
        @(negedge clk);
        strobe_i = 1'b0;
        mute_i   = ~m;
        sample_i = ~sample_i;
    endtask

    function automatic int rnd_sample();
        return int'($signed(16'($urandom)));
    endfunction

    always @(posedge clk) last_strobe <= rst_n && strobe_i;

    // Monitor: validity timing and scoreboard pops.
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            check(valid_o == last_strobe, "R2", int'(valid_o), int'(last_strobe));
            if (valid_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", 1, 0);
                end else begin
                    int    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(int'($signed(sample_o)) == e, t, int'($signed(sample_o)), e);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 during reset
        check(gain_o == 8'd245, "R1", int'(gain_o), 245);
        check(sample_o == 16'd0, "R1", int'(sample_o), 0);
        check(valid_o == 1'b0, "R1", int'(valid_o), 0);
        check(muted_o == 1'b0, "R1", int'(muted_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(gain_o == 8'd245 && !valid_o && !muted_o, "R1", int'(gain_o), 245);

        // Unity gain pass-through, extremes (R7)
        drive(32767, 1'b0, "R4");
        drive(-32768, 1'b0, "R4");
        drive(0, 1'b0, "R4");
        drive(-1, 1'b0, "R4");
        drive(1, 1'b0, "R4");
        for (int i = 0; i < 6; i++) drive(rnd_sample(), 1'b0, "R4");

        // Full fade down and hold at zero (R3, R7, R8)
        drive(-32768, 1'b1, "R3");
        for (int i = 0; i < 249; i++) drive(rnd_sample(), 1'b1, "R3");
        drive(32767, 1'b1, "R3");

        // Rise part way, then reverse in mid-ramp (R5)
        for (int i = 0; i < 100; i++) drive(rnd_sample(), 1'b0, "R4");
        for (int i = 0; i < 40; i++) drive(rnd_sample(), 1'b1, "R5");
        for (int i = 0; i < 10; i++) drive(rnd_sample(), 1'b0, "R5");
        // Fall to exactly one, release there
        for (int i = 0; i < 69; i++) drive(rnd_sample(), 1'b1, "R3");
        drive(32767, 1'b0, "R5");
        drive(-32768, 1'b1, "R5");
        drive(-32768, 1'b1, "R5");
        // Release on the strobe that sees zero
        drive(12345, 1'b0, "R5");
        for (int i = 0; i < 250; i++) drive(rnd_sample(), 1'b0, "R4");
        drive(-32768, 1'b0, "R4");
        drive(32767, 1'b0, "R4");

        // Drain: no stray valid
        repeat (4) @(negedge clk);
        #2;
        check(exp_q.size() == 0, "R2", exp_q.size(), 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule